// File: doc/BRIEF.md
# PCIe Root-Port Link Bring-Up Sequencer

This block is a hardware state machine that takes one PCIe root-port link from reset to a trained link. A single-cycle start request begins a run. If the link already reports up at that moment, the run ends at once and no output moves. Otherwise the sequencer enables the application clock and asserts the slot reset (PERST#, active low). If the port strap asks for it, the sequencer also raises slot power. It then brings up the two reference clocks one at a time, each with a request and acknowledge handshake. It enables both clock outputs and the port-level reference clock, holds PERST# for a settling time and then releases it. After that it waits for the port to report ready, clears the clock-gating-disable controls and pulses the link-training start strobe. Finally it waits for link-up.

Every delay and timeout is counted in pulses of a free-running tick input, normally one per microsecond. Each is set by a parameter, so a faster tick or smaller values shorten a run. Each wait gives up after a set number of polls. The last failed step is reported in a 2-bit code that stays valid while the done pulse is high and until the next accepted start.

Top module: `pcie_bringup_seq`

## Requirements
- R1: If `link_up_i` is high in the cycle a start is accepted, `done_o` pulses in the next cycle, `err_o` reads 0, and no link-control output changes.
- R2: A run raises `app_clk_en_o`, then drives `perst_n_o` low, then raises `pwr_en_o` (when selected), then raises `refclk_req_o[0]`, each strictly after the one before it.
- R3: `refclk_req_o[1]` rises only after `refclk_ack_i[0]` has been seen high, or after the reference-clock-0 wait has expired.
- R4: Once both acknowledge waits end, `refclk_en_o` reads 2'b11 and `port_refclk_en_o` reads 1 while PERST# is still low.
- R5: PERST# stays low for HOLD_PWR_TICKS ticks after the clocks are enabled when `pwr_sel_i` was high at start, and for HOLD_TICKS ticks otherwise (up to two extra ticks of sampling slack).
- R6: If port-ready does not arrive within RDY_POLLS*POLL_TICKS ticks, the run ends with `err_o`=2, no training strobe, and both clock-gating-disable outputs still 1.
- R7: Both clock-gating-disable outputs read 0 when the single-cycle `train_start_o` pulse fires, and each successful run gives exactly one such pulse.
- R8: If link-up does not arrive within LINK_POLLS*POLL_TICKS ticks after the strobe, the run ends with `err_o`=3.
- R9: A reference-clock acknowledge timeout sets `err_o`=1 but does not stop the run: the next step proceeds and training is still started.
- R10: A start pulse while `busy_o` is high has no effect: the run in progress finishes with one done pulse and one training strobe.
- R11: With `pwr_sel_i` low at start, `pwr_en_o` stays 0 for the whole run.
- R12: After reset: `app_clk_en_o`, `pwr_en_o`, `refclk_req_o`, `refclk_en_o`, `port_refclk_en_o`, `train_start_o`, `done_o`, `busy_o` and `err_o` are 0; `perst_n_o`, `refclk_cgdis_o` and `app_cgdis_o` are 1. A run with every response in time ends with `err_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Single-cycle run request |
| pwr_sel_i | input | 1 | Slot power control in use; sampled at start |
| tick_i | input | 1 | Time-base pulse, one cycle wide |
| refclk_ack_i | input | 2 | Reference clock acknowledges, bit 0 = clock 0 |
| port_ready_i | input | 1 | Port reports ready after reset release |
| link_up_i | input | 1 | Link is up |
| app_clk_en_o | output | 1 | Application clock enable |
| perst_n_o | output | 1 | Slot reset, low = asserted |
| pwr_en_o | output | 1 | Slot power enable |
| refclk_req_o | output | 2 | Reference clock requests |
| refclk_en_o | output | 2 | Reference clock output enables |
| port_refclk_en_o | output | 1 | Port-level reference clock enable |
| refclk_cgdis_o | output | 1 | Reference clock gating disable |
| app_cgdis_o | output | 1 | Application clock gating disable |
| train_start_o | output | 1 | Link-training start strobe |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | End-of-run pulse |
| err_o | output | 2 | 0 ok, 1 refclk ack timeout, 2 ready timeout, 3 link-up timeout |

## Verification
The bench goes after the corner cases where a plausible design goes wrong.

- Link already up at start: a careless design would begin the sequence anyway.
- Acknowledge to clock 0 withheld: a design that aborts there would never pulse training. One that skips the handshake would request clock 1 early.
- Port never ready: a faulty design would still strobe training or clear the gating controls.
- Link never comes up: the error code must read 3.
- PERST# hold measured in ticks with and without slot power: a design that ignores the strap would give the same hold time in both cases.
- Second start during a run: a design that restarts would give two done pulses or two training strobes.

// File: rtl/bup_pkg.sv
package bup_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_APP, S_PERST, S_PWR, S_REQ0, S_WAIT0, S_REQ1, S_WAIT1,
    S_CLKEN, S_HOLD, S_RELEASE, S_WAIT_RDY, S_UNGATE, S_TRAIN, S_WAIT_LINK, S_FINISH
  } bup_state_e;

  typedef enum logic [1:0] {LIM_ACK, LIM_HOLD, LIM_RDY, LIM_LINK} bup_lim_e;

  localparam logic [1:0] ERR_NONE = 2'd0;
  localparam logic [1:0] ERR_ACK  = 2'd1;
  localparam logic [1:0] ERR_RDY  = 2'd2;
  localparam logic [1:0] ERR_LINK = 2'd3;
endpackage

// File: rtl/bup_tick_count.sv
module bup_tick_count #(
  parameter int CNT_W = 18
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             expired_o
);
  logic [CNT_W-1:0] cnt_q;

  assign expired_o = (cnt_q >= limit_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (clr_i)                 cnt_q <= '0;
    else if (tick_i && !expired_o)  cnt_q <= cnt_q + 1'b1;
  end

  // R5
  clr_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0));
endmodule

// File: rtl/bup_fsm.sv
module bup_fsm
  import bup_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       pwr_sel_i,
  input  logic [1:0] refclk_ack_i,
  input  logic       port_ready_i,
  input  logic       link_up_i,
  input  logic       expired_i,
  output logic       tmr_clr_o,
  output bup_lim_e   lim_sel_o,
  output logic       app_clk_en_o,
  output logic       perst_n_o,
  output logic       pwr_en_o,
  output logic [1:0] refclk_req_o,
  output logic [1:0] refclk_en_o,
  output logic       port_refclk_en_o,
  output logic       refclk_cgdis_o,
  output logic       app_cgdis_o,
  output logic       train_start_o,
  output logic       busy_o,
  output logic       done_o,
  output logic [1:0] err_o
);
  bup_state_e state_q, state_d;
  logic       pwr_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE:      if (start_i) state_d = link_up_i ? S_FINISH : S_APP;
      S_APP:       state_d = S_PERST;
      S_PERST:     state_d = S_PWR;
      S_PWR:       state_d = S_REQ0;
      S_REQ0:      state_d = S_WAIT0;
      S_WAIT0:     if (refclk_ack_i[0] || expired_i) state_d = S_REQ1;
      S_REQ1:      state_d = S_WAIT1;
      S_WAIT1:     if (refclk_ack_i[1] || expired_i) state_d = S_CLKEN;
      S_CLKEN:     state_d = S_HOLD;
      S_HOLD:      if (expired_i) state_d = S_RELEASE;
      S_RELEASE:   state_d = S_WAIT_RDY;
      S_WAIT_RDY:  if (port_ready_i) state_d = S_UNGATE;
                   else if (expired_i) state_d = S_FINISH;
      S_UNGATE:    state_d = S_TRAIN;
      S_TRAIN:     state_d = S_WAIT_LINK;
      S_WAIT_LINK: if (link_up_i || expired_i) state_d = S_FINISH;
      S_FINISH:    state_d = S_IDLE;
      default:     state_d = S_IDLE;
    endcase
  end

  always_comb begin
    unique case (state_q)
      S_WAIT0, S_WAIT1: lim_sel_o = LIM_ACK;
      S_HOLD:           lim_sel_o = LIM_HOLD;
      S_WAIT_RDY:       lim_sel_o = LIM_RDY;
      default:          lim_sel_o = LIM_LINK;
    endcase
  end

  // timer restarts in the step ahead of each wait
  assign tmr_clr_o = (state_q == S_REQ0) || (state_q == S_REQ1) || (state_q == S_CLKEN) ||
                     (state_q == S_RELEASE) || (state_q == S_TRAIN);
  assign train_start_o = (state_q == S_TRAIN);
  assign done_o        = (state_q == S_FINISH);
  assign busy_o        = (state_q != S_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q          <= S_IDLE;
      pwr_q            <= 1'b0;
      app_clk_en_o     <= 1'b0;
      perst_n_o        <= 1'b1;
      pwr_en_o         <= 1'b0;
      refclk_req_o     <= '0;
      refclk_en_o      <= '0;
      port_refclk_en_o <= 1'b0;
      refclk_cgdis_o   <= 1'b1;
      app_cgdis_o      <= 1'b1;
      err_o            <= ERR_NONE;
    end else begin
      state_q <= state_d;
      unique case (state_q)
        S_IDLE: if (start_i) begin
          err_o <= ERR_NONE;
          pwr_q <= pwr_sel_i;
        end
        S_APP:     app_clk_en_o <= 1'b1;
        S_PERST:   perst_n_o    <= 1'b0;
        S_PWR:     if (pwr_q) pwr_en_o <= 1'b1;
        S_REQ0:    refclk_req_o[0] <= 1'b1;
        S_WAIT0:   if (!refclk_ack_i[0] && expired_i) err_o <= ERR_ACK;
        S_REQ1:    refclk_req_o[1] <= 1'b1;
        S_WAIT1:   if (!refclk_ack_i[1] && expired_i) err_o <= ERR_ACK;
        S_CLKEN: begin
          refclk_en_o      <= 2'b11;
          port_refclk_en_o <= 1'b1;
        end
        S_RELEASE: perst_n_o <= 1'b1;
        S_WAIT_RDY: if (!port_ready_i && expired_i) err_o <= ERR_RDY;
        S_UNGATE: begin
          refclk_cgdis_o <= 1'b0;
          app_cgdis_o    <= 1'b0;
        end
        S_WAIT_LINK: if (!link_up_i && expired_i) err_o <= ERR_LINK;
        default: ;
      endcase
    end
  end

  // R1
  link_up_skip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i && link_up_i) |=> (done_o && $stable(perst_n_o) && $stable(app_clk_en_o)));
  // R2
  req0_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(refclk_req_o[0]) |-> (app_clk_en_o && !perst_n_o));
  // R4
  clk_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(port_refclk_en_o) |-> (refclk_req_o == 2'b11 && refclk_en_o == 2'b11 && !perst_n_o));
  // R6
  train_released_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    train_start_o |-> perst_n_o);
  // R7
  ungate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    train_start_o |-> (!refclk_cgdis_o && !app_cgdis_o));
  // R12
  pulse_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({done_o, train_start_o}));
endmodule

// File: rtl/pcie_bringup_seq.sv
module pcie_bringup_seq
  import bup_pkg::*;
#(
  parameter int POLL_TICKS     = 100,
  parameter int ACK_POLLS      = 500,
  parameter int RDY_POLLS      = 2500,
  parameter int LINK_POLLS     = 1000,
  parameter int HOLD_PWR_TICKS = 100000,
  parameter int HOLD_TICKS     = 100
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       pwr_sel_i,
  input  logic       tick_i,
  input  logic [1:0] refclk_ack_i,
  input  logic       port_ready_i,
  input  logic       link_up_i,
  output logic       app_clk_en_o,
  output logic       perst_n_o,
  output logic       pwr_en_o,
  output logic [1:0] refclk_req_o,
  output logic [1:0] refclk_en_o,
  output logic       port_refclk_en_o,
  output logic       refclk_cgdis_o,
  output logic       app_cgdis_o,
  output logic       train_start_o,
  output logic       busy_o,
  output logic       done_o,
  output logic [1:0] err_o
);
  localparam int ACK_LIM  = ACK_POLLS * POLL_TICKS;
  localparam int RDY_LIM  = RDY_POLLS * POLL_TICKS;
  localparam int LINK_LIM = LINK_POLLS * POLL_TICKS;
  localparam int MAX_A    = (ACK_LIM > RDY_LIM) ? ACK_LIM : RDY_LIM;
  localparam int MAX_B    = (LINK_LIM > HOLD_PWR_TICKS) ? LINK_LIM : HOLD_PWR_TICKS;
  localparam int MAX_C    = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int MAX_LIM  = (MAX_C > HOLD_TICKS) ? MAX_C : HOLD_TICKS;
  localparam int CNT_W    = $clog2(MAX_LIM + 1);

  logic             tmr_clr, expired;
  bup_lim_e         lim_sel;
  logic [CNT_W-1:0] limit;

  always_comb begin
    unique case (lim_sel)
      LIM_ACK:  limit = CNT_W'(ACK_LIM);
      LIM_HOLD: limit = pwr_en_o ? CNT_W'(HOLD_PWR_TICKS) : CNT_W'(HOLD_TICKS);
      LIM_RDY:  limit = CNT_W'(RDY_LIM);
      default:  limit = CNT_W'(LINK_LIM);
    endcase
  end

  bup_tick_count #(.CNT_W(CNT_W)) u_tmr (
    .clk_i, .rst_ni, .clr_i(tmr_clr), .tick_i, .limit_i(limit), .expired_o(expired)
  );

  bup_fsm u_fsm (
    .clk_i, .rst_ni, .start_i, .pwr_sel_i, .refclk_ack_i, .port_ready_i, .link_up_i,
    .expired_i(expired), .tmr_clr_o(tmr_clr), .lim_sel_o(lim_sel),
    .app_clk_en_o, .perst_n_o, .pwr_en_o, .refclk_req_o, .refclk_en_o,
    .port_refclk_en_o, .refclk_cgdis_o, .app_cgdis_o, .train_start_o,
    .busy_o, .done_o, .err_o
  );
endmodule

// File: tb/sim_pcie_bringup_seq.sv
module sim_pcie_bringup_seq;
  localparam int PT = 2, AP = 4, RP = 5, LP = 4, HPW = 30, HNP = 5;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, pwr_sel = 1'b0, tick = 1'b0;
  logic [1:0] ack = '0;
  logic rdy = 1'b0, link = 1'b0;
  logic app_en, perst_n, pwr_en, port_en, rcg, acg, train, busy, done;
  logic [1:0] req, ren, err;

  always #10 clk = ~clk;

  pcie_bringup_seq #(.POLL_TICKS(PT), .ACK_POLLS(AP), .RDY_POLLS(RP), .LINK_POLLS(LP),
                     .HOLD_PWR_TICKS(HPW), .HOLD_TICKS(HNP)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .pwr_sel_i(pwr_sel), .tick_i(tick),
    .refclk_ack_i(ack), .port_ready_i(rdy), .link_up_i(link),
    .app_clk_en_o(app_en), .perst_n_o(perst_n), .pwr_en_o(pwr_en), .refclk_req_o(req),
    .refclk_en_o(ren), .port_refclk_en_o(port_en), .refclk_cgdis_o(rcg), .app_cgdis_o(acg),
    .train_start_o(train), .busy_o(busy), .done_o(done), .err_o(err)
  );

  int checks = 0, errors = 0, cyc = 0;
  logic [1:0] ack_en = 2'b11;
  logic rdy_en = 1'b1, link_en = 1'b1, link_pre = 1'b0;
  int c0 = 0, c1 = 0;
  int dones, trains, err_done, hold_ticks, pwr_seen, cg_at_train;
  int t_app, t_perst, t_pwr, t_req0, t_req1, t_ack0;

  task automatic clear_mon();
    dones = 0; trains = 0; err_done = -1; hold_ticks = 0; pwr_seen = 0; cg_at_train = -1;
    t_app = -1; t_perst = -1; t_pwr = -1; t_req0 = -1; t_req1 = -1; t_ack0 = -1;
  endtask

  // environment model and monitor, all at the falling edge
  always @(negedge clk) begin
    cyc++;
    if (done) begin dones++; err_done = err; end
    if (train) begin trains++; cg_at_train = {rcg, acg}; end
    if (pwr_en) pwr_seen = 1;
    if (app_en && t_app < 0) t_app = cyc;
    if (!perst_n && t_perst < 0) t_perst = cyc;
    if (pwr_en && t_pwr < 0) t_pwr = cyc;
    if (req[0] && t_req0 < 0) t_req0 = cyc;
    if (req[1] && t_req1 < 0) t_req1 = cyc;
    if (ack[0] && t_ack0 < 0) t_ack0 = cyc;
    if (port_en && !perst_n && tick) hold_ticks++;
    c0 = req[0] ? c0 + 1 : 0;
    c1 = req[1] ? c1 + 1 : 0;
    ack[0] <= ack_en[0] && (c0 > 5);
    ack[1] <= ack_en[1] && (c1 > 5);
    rdy  <= rdy_en && perst_n && app_en;
    link <= link_pre || (link_en && trains > 0);
    tick <= ~tick;
    if (cyc > 100000) begin
      errors++; checks++;
      $display("FAIL watchdog: act=%0d exp=<100000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; start = 1'b0;
    step(); step();
    rst_n = 1'b1;
    step();
    clear_mon();
  endtask

  task automatic run(bit pwr, logic [1:0] aen, bit ren_i, bit len, bit lpre);
    do_reset();
    pwr_sel = pwr; ack_en = aen; rdy_en = ren_i; link_en = len; link_pre = lpre;
    step();
    start = 1'b1; step(); start = 1'b0;
    for (int i = 0; i < 3000 && dones == 0; i++) step();
    for (int i = 0; i < 10; i++) step();
  endtask

  task automatic t_reset();
    do_reset();
    chk({app_en, pwr_en, req, ren, port_en, train, done, busy, err} == 0, "R12 reset zeros",
        {app_en, pwr_en, req, ren, port_en, train, done, busy, err}, 0);
    chk({perst_n, rcg, acg} == 3'b111, "R12 reset ones", {perst_n, rcg, acg}, 7);
  endtask

  task automatic t_link_up();
    do_reset();
    link_pre = 1'b1; link_en = 1'b0;
    step();
    start = 1'b1; step(); start = 1'b0;
    chk(done == 1'b1, "R1 done next cycle", done, 1);
    chk(err == 2'd0, "R1 err", err, 0);
    chk(app_en == 0 && perst_n == 1 && req == 0 && port_en == 0, "R1 outputs untouched",
        {app_en, perst_n, req, port_en}, 8);
    link_pre = 1'b0;
  endtask

  task automatic t_good_pwr();
    run(1'b1, 2'b11, 1'b1, 1'b1, 1'b0);
    chk(t_app < t_perst && t_perst < t_pwr && t_pwr < t_req0 && t_app > 0, "R2 order",
        t_req0 - t_app, 3);
    chk(t_ack0 > 0 && t_req1 > t_ack0, "R3 req1 after ack0", t_req1, t_ack0 + 1);
    chk(ren == 2'b11 && port_en == 1, "R4 clocks enabled", {ren, port_en}, 7);
    chk(hold_ticks >= HPW && hold_ticks <= HPW + 2, "R5 hold with power", hold_ticks, HPW);
    chk(trains == 1 && cg_at_train == 0, "R7 ungated single strobe", trains * 10 + cg_at_train, 10);
    chk(err_done == 0 && dones == 1, "R12 clean run", err_done, 0);
  endtask

  task automatic t_good_nopwr();
    run(1'b0, 2'b11, 1'b1, 1'b1, 1'b0);
    chk(pwr_seen == 0, "R11 power stays off", pwr_seen, 0);
    chk(hold_ticks >= HNP && hold_ticks <= HNP + 2, "R5 hold without power", hold_ticks, HNP);
    chk(err_done == 0, "R12 clean run nopwr", err_done, 0);
  endtask

  task automatic t_ack_to();
    run(1'b0, 2'b10, 1'b1, 1'b1, 1'b0);
    chk(err_done == 1, "R9 ack timeout code", err_done, 1);
    chk(t_req1 > 0 && trains == 1, "R9 run continues", trains, 1);
    chk(t_ack0 < 0, "R3 req1 after timeout only", t_ack0, -1);
  endtask

  task automatic t_rdy_to();
    run(1'b1, 2'b11, 1'b0, 1'b1, 1'b0);
    chk(err_done == 2, "R6 ready timeout code", err_done, 2);
    chk(trains == 0, "R6 no training", trains, 0);
    chk(rcg == 1 && acg == 1, "R6 gating kept", {rcg, acg}, 3);
  endtask

  task automatic t_link_to();
    run(1'b0, 2'b11, 1'b1, 1'b0, 1'b0);
    chk(err_done == 3, "R8 link timeout code", err_done, 3);
    chk(trains == 1, "R8 strobe fired", trains, 1);
  endtask

  task automatic t_restart();
    do_reset();
    pwr_sel = 1'b1; ack_en = 2'b11; rdy_en = 1'b1; link_en = 1'b1; link_pre = 1'b0;
    step();
    start = 1'b1; step(); start = 1'b0;
    for (int i = 0; i < 500 && port_en == 0; i++) step();
    start = 1'b1; step(); start = 1'b0;
    for (int i = 0; i < 3000 && dones == 0; i++) step();
    for (int i = 0; i < 30; i++) step();
    chk(dones == 1 && trains == 1, "R10 restart ignored", dones * 10 + trains, 11);
    chk(err_done == 0 && busy == 0, "R10 run completes", err_done, 0);
  endtask

  initial begin
    clear_mon();
    t_reset();
    t_link_up();
    t_good_pwr();
    t_good_nopwr();
    t_ack_to();
    t_rdy_to();
    t_link_to();
    t_restart();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule